// File: doc/BRIEF.md
# Seven-Channel Digital Volume with Gain Ramping and Silence Detection

This block scales time-multiplexed audio samples for seven channels (six full-band outputs and a subwoofer). Each channel holds a target attenuation code and a mute flag. Both are written through a small configuration port. Each channel also holds an applied code, which is the code actually used on its samples. On every accepted sample the applied code steps once toward the target, so a volume change fades in rather than clicking.

The code covers 0.5 dB steps from -103.5 dB (code 0) up to +24 dB (code 255), with code 207 as unity gain. The decibel value is turned into a linear factor by a twelve-entry mantissa lookup plus a binary shift, and the product is clamped to the output word. A long run of silent input makes a channel drop its applied code to the minimum on its own. Sound then fades back in from the bottom once signal returns.

Top module: `chan_volume`

## Requirements
- R1: After reset every channel has target code 207 and applied code 207 (0 dB), mute is off, `out_vld` is 0 and `out_data` is 0. A sample sent right after reset leaves the block unchanged in value.
- R2: The output equals the input times 10^((code-207)/40), where code is the channel's applied code at the moment of the strobe. Code 255 gives +24 dB and code 0 gives -103.5 dB. The result must lie within 5 % of the ideal value plus 2 LSB.
- R3: An accepted sample (`in_vld` high with `in_ch` below 7) gives `out_vld` high exactly one clock later, with `out_ch` equal to the sample's channel. With no sample, `out_vld` is low.
- R4: After a sample is scaled, that channel's applied code moves one step (±1) toward its effective target. The effective target is 0 while the channel is muted and the written code otherwise. The applied code stops when it reaches the effective target.
- R5: A configuration write changes only the channel named by `cfg_ch`.
- R6: While mute is set, the applied code ramps down to 0. Once the applied code is 0, the output is exactly 0. Clearing mute ramps the gain back up from code 0.
- R7: After 1024 consecutive zero input samples on a channel, that channel's applied code is forced to 0. The first non-zero sample is scaled at code 0 and restarts the ramp upward. A run of 1023 zeros has no such effect.
- R8: Results that do not fit in 24 bits clamp to +8388607 or -8388608.
- R9: If a write to a channel and a sample on that channel fall in the same cycle, the sample is scaled with the applied code from before the write. The ramp step in that same cycle heads toward the newly written target.
- R10: A strobe with `in_ch` equal to 7 is ignored, and `out_vld` stays low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 3 | Channel written |
| cfg_code | input | 8 | Target gain code, 0.5 dB per step, 207 = 0 dB |
| cfg_mute | input | 1 | Mute flag for the channel written |
| in_vld | input | 1 | Sample strobe |
| in_ch | input | 3 | Channel of the incoming sample |
| in_data | input | 24 | Signed input sample |
| out_vld | output | 1 | Output sample valid |
| out_ch | output | 3 | Channel of the output sample |
| out_data | output | 24 | Signed, scaled and clamped output sample |

## Verification
A configuration write and a sample strobe can hit the same channel in the same clock. In that case the scaling must use the old applied code, while the ramp step must follow the new target. The bench provokes this by driving both strobes in one cycle after the channel has settled on a code higher than the newly written one. It then judges the sample from that cycle and the next one against a reference model: the first sample must be scaled at the old code, and the second at one code lower. The same model tracks every applied code through the ramps, the mutes and the zero runs, so each output is compared against its ideal decibel gain.

// File: rtl/chan_volume.sv
`timescale 1ns/1ps
module chan_volume #(
  parameter int NCH      = 7,
  parameter int DW       = 24,
  parameter int CODE_W   = 8,
  parameter int UNITY    = 207,
  parameter int ZERO_RUN = 1024,
  parameter int CHW      = $clog2(NCH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [CHW-1:0]       cfg_ch,
  input  logic [CODE_W-1:0]    cfg_code,
  input  logic                 cfg_mute,
  input  logic                 in_vld,
  input  logic [CHW-1:0]       in_ch,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_vld,
  output logic [CHW-1:0]       out_ch,
  output logic signed [DW-1:0] out_data
);
  localparam int MW   = 17;
  localparam int PW   = DW + MW;
  localparam int ZW   = $clog2(ZERO_RUN + 1);
  localparam int OFS  = (12 - (UNITY % 12)) % 12;
  localparam int SH0  = 15 + (UNITY + OFS) / 12;

  logic [CODE_W-1:0] tgt  [NCH];
  logic [CODE_W-1:0] cur  [NCH];
  logic [ZW-1:0]     zcnt [NCH];
  logic [NCH-1:0]    mute;

  function automatic logic [15:0] mant(input int k);
    case (k)
      1:  mant = 16'd34710;
      2:  mant = 16'd36766;
      3:  mant = 16'd38945;
      4:  mant = 16'd41252;
      5:  mant = 16'd43697;
      6:  mant = 16'd46286;
      7:  mant = 16'd49029;
      8:  mant = 16'd51934;
      9:  mant = 16'd55011;
      10: mant = 16'd58271;
      11: mant = 16'd61724;
      default: mant = 16'd32768;
    endcase
  endfunction

  wire in_ok  = in_vld && (int'(in_ch) < NCH);
  wire cfg_ok = cfg_we && (int'(cfg_ch) < NCH);
  wire wr_hit = cfg_ok && (cfg_ch == in_ch);

  logic [CODE_W-1:0]    a_code, eff, nxt;
  logic                 a_mute;
  logic signed [PW-1:0] prod, scaled;
  logic signed [DW-1:0] sat;
  int                   ev, sh;

  always_comb begin
    a_code = in_ok ? cur[in_ch] : '0;
    a_mute = in_ok ? mute[in_ch] : 1'b0;
    if (wr_hit)
      eff = cfg_mute ? '0 : cfg_code;
    else
      eff = (in_ok && !mute[in_ch]) ? tgt[in_ch] : '0;
    if (a_code < eff)      nxt = a_code + 1'b1;
    else if (a_code > eff) nxt = a_code - 1'b1;
    else                   nxt = a_code;

    ev     = int'(a_code) + OFS;
    sh     = SH0 - ev / 12;
    prod   = $signed(in_data) * $signed({1'b0, mant(ev % 12)});
    scaled = prod >>> sh;
    if (!scaled[PW-1] && (|scaled[PW-2:DW-1]))
      sat = {1'b0, {(DW-1){1'b1}}};
    else if (scaled[PW-1] && !(&scaled[PW-2:DW-1]))
      sat = {1'b1, {(DW-1){1'b0}}};
    else
      sat = scaled[DW-1:0];
  end

  wire silent = a_mute && (a_code == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        tgt[i]  <= CODE_W'(UNITY);
        cur[i]  <= CODE_W'(UNITY);
        zcnt[i] <= '0;
      end
      mute     <= '0;
      out_vld  <= 1'b0;
      out_ch   <= '0;
      out_data <= '0;
    end else begin
      if (cfg_ok) begin
        tgt[cfg_ch]  <= cfg_code;
        mute[cfg_ch] <= cfg_mute;
      end
      if (in_ok) begin
        if (in_data == '0) begin
          if (zcnt[in_ch] >= ZW'(ZERO_RUN - 1)) begin
            zcnt[in_ch] <= ZW'(ZERO_RUN);
            cur[in_ch]  <= '0;
          end else begin
            zcnt[in_ch] <= zcnt[in_ch] + 1'b1;
            cur[in_ch]  <= nxt;
          end
        end else begin
          zcnt[in_ch] <= '0;
          cur[in_ch]  <= nxt;
        end
      end
      out_vld <= in_ok;
      if (in_ok) begin
        out_ch   <= in_ch;
        out_data <= silent ? '0 : sat;
      end
    end
  end
endmodule

// File: rtl/chan_volume_chk.sv
`timescale 1ns/1ps
module chan_volume_chk #(
  parameter int NCH = 7,
  parameter int DW  = 24,
  parameter int CHW = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_vld,
  input logic [CHW-1:0]       in_ch,
  input logic signed [DW-1:0] in_data,
  input logic                 out_vld,
  input logic [CHW-1:0]       out_ch,
  input logic signed [DW-1:0] out_data
);
  wire acc = in_vld && (int'(in_ch) < NCH);

  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) acc |=> out_vld); // R3
  AST_CH_ECHO: assert property (@(posedge clk) disable iff (!rst_n) acc |=> out_ch == $past(in_ch)); // R3
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n) !in_vld |=> !out_vld); // R3
  AST_BAD_CH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n) (in_vld && !acc) |=> !out_vld); // R10
  AST_ZERO_STAYS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (acc && in_data == '0) |=> out_data == '0); // R2
endmodule

bind chan_volume chan_volume_chk #(.NCH(NCH), .DW(DW), .CHW(CHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_ch(in_ch), .in_data(in_data),
  .out_vld(out_vld), .out_ch(out_ch), .out_data(out_data)
);

// File: tb/sim_chan_volume.sv
`timescale 1ns/1ps
module sim_chan_volume;
  localparam int NCH = 7;
  localparam int MAXP = 8388607;
  localparam int MINN = -8388608;

  logic clk = 0;
  always #2.5 clk = ~clk;

  logic rst_n, cfg_we, cfg_mute, in_vld, out_vld;
  logic [2:0] cfg_ch, in_ch, out_ch;
  logic [7:0] cfg_code;
  logic signed [23:0] in_data, out_data;

  chan_volume u0 (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
    .cfg_code(cfg_code), .cfg_mute(cfg_mute), .in_vld(in_vld), .in_ch(in_ch),
    .in_data(in_data), .out_vld(out_vld), .out_ch(out_ch), .out_data(out_data));

  int checks = 0, fails = 0;
  int cur_m[NCH], tg_m[NCH], zc_m[NCH];
  bit mu_m[NCH];

  localparam int VEC[8][3] = '{
    '{0, 255, 100000}, '{1, 207, -5000}, '{2, 195, 400000}, '{3, 0, 8388607},
    '{4, 100, -3000000}, '{5, 255, 8000000}, '{6, 255, -8000000}, '{0, 230, 123456}};

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic xfer(input int ch, input int data, input bit wr, input int wch,
                      input int wcode, input bit wmute, input string tag);
    real e, tol;
    int expi, eff;
    bit zero_forced;
    @(negedge clk);
    cfg_we = wr; cfg_ch = wch[2:0]; cfg_code = wcode[7:0]; cfg_mute = wmute;
    in_vld = (ch >= 0); in_ch = ch[2:0]; in_data = data[23:0];
    if (wr) begin tg_m[wch] = wcode; mu_m[wch] = wmute; end
    expi = 0; tol = 0.0; e = 0.0;
    if (ch >= 0) begin
      zero_forced = mu_m[ch] && cur_m[ch] == 0;
      e = data * (10.0 ** ((cur_m[ch] - 207) / 40.0));
      if (zero_forced) expi = 0;
      else if (e > MAXP) expi = MAXP;
      else if (e < MINN) expi = MINN;
      else begin expi = $rtoi(e); tol = 0.05 * (e < 0 ? -e : e) + 2.0; end
    end
    @(negedge clk);
    cfg_we = 0; in_vld = 0;
    if (ch >= 0) begin
      check(out_vld === 1'b1 && out_ch === ch[2:0], {tag, " R3"}, int'(out_ch), ch);
      if (tol == 0.0) check(int'(out_data) == expi, tag, int'(out_data), expi);
      else check((out_data - e) <= tol && (e - out_data) <= tol, tag, int'(out_data), expi);
      eff = mu_m[ch] ? 0 : tg_m[ch];
      if (data == 0 && zc_m[ch] >= 1023) begin zc_m[ch] = 1024; cur_m[ch] = 0; end
      else begin
        zc_m[ch] = (data == 0) ? zc_m[ch] + 1 : 0;
        if (cur_m[ch] < eff) cur_m[ch]++;
        else if (cur_m[ch] > eff) cur_m[ch]--;
      end
    end
  endtask

  task automatic settle(input int ch, input int data, input string tag);
    int eff;
    eff = mu_m[ch] ? 0 : tg_m[ch];
    while (cur_m[ch] != eff) xfer(ch, data, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog R3 actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCH; i++) begin cur_m[i] = 207; tg_m[i] = 207; zc_m[i] = 0; mu_m[i] = 0; end
    rst_n = 0; cfg_we = 0; cfg_ch = 0; cfg_code = 0; cfg_mute = 0;
    in_vld = 0; in_ch = 0; in_data = 0;
    repeat (5) @(negedge clk);
    check(out_vld === 1'b0 && out_data === 24'sd0, "R1 reset outputs", int'(out_data), 0);
    rst_n = 1;
    xfer(0, 1000, 0, 0, 0, 0, "R1 unity after reset");

    for (int i = 0; i < 8; i++) begin
      xfer(-1, 0, 1, VEC[i][0], VEC[i][1], 0, "R5");
      settle(VEC[i][0], 1000, "R4 ramp");
      xfer(VEC[i][0], VEC[i][2], 0, 0, 0, 0, "R2/R8 table");
    end

    xfer(-1, 0, 1, 1, 210, 0, "R4");
    for (int i = 0; i < 4; i++) xfer(1, 10000, 0, 0, 0, 0, "R4 step");
    xfer(1, 20000, 1, 1, 200, 0, "R9 same-cycle sample old code");
    xfer(1, 20000, 0, 0, 0, 0, "R9 next sample new direction");
    check(cur_m[1] == 208, "R9 model", cur_m[1], 208);

    xfer(-1, 0, 1, 2, 195, 1, "R6");
    xfer(3, 8000000, 0, 0, 0, 0, "R5 neighbour unaffected");
    settle(2, 400000, "R6 mute ramp");
    for (int i = 0; i < 3; i++) xfer(2, 400000, 0, 0, 0, 0, "R6 muted zero");
    xfer(-1, 0, 1, 2, 195, 0, "R6");
    xfer(2, 4000000, 0, 0, 0, 0, "R6 unmute from bottom");
    xfer(2, 4000000, 0, 0, 0, 0, "R6 unmute step");

    for (int i = 0; i < 1023; i++) xfer(4, 0, 0, 0, 0, 0, "R7 zeros");
    xfer(4, 3000000, 0, 0, 0, 0, "R7 1023 zeros no effect");
    for (int i = 0; i < 1024; i++) xfer(4, 0, 0, 0, 0, 0, "R7 zeros");
    xfer(4, 4000000, 0, 0, 0, 0, "R7 released at bottom");
    xfer(4, 4000000, 0, 0, 0, 0, "R7 ramp back up");

    @(negedge clk);
    in_vld = 1; in_ch = 3'd7; in_data = 24'sd5000;
    @(negedge clk);
    in_vld = 0;
    check(out_vld === 1'b0, "R10 bad channel", int'(out_vld), 0);
    xfer(3, 8000000, 0, 0, 0, 0, "R10 state intact");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule